// File: doc/BRIEF.md
# Parallel Bus Write Strobe Sequencer

This block drives the write side of an 8080-style parallel display bus. A client hands it one write at a time, an address and a data word, over a valid/ready request port. The block places the address on the bus and runs four timed phases: address setup with chip select still high, chip select low before the write strobe, the write strobe pulse, and a hold with chip select low after the strobe. Each phase lasts its programmed count plus one cycle of the single clock. It then releases chip select and goes idle.

The four phase counts live in 4-bit timing registers that are loaded through a write-enable strobe. They reset to zero for every phase except the strobe width, which resets to one. A write takes a snapshot of all four counts when it is accepted, so reprogramming during a write only affects later writes. The read strobe is held inactive, since the bus only idles for reads. Address and data outputs keep their last values while the bus is idle.

Top module: `i80_write_timer`

## Requirements
- R1: After a request is accepted, the bus address shows the request address from the next cycle, and chip select stays high for exactly (address-setup count + 1) cycles before it goes low.
- R2: The write strobe goes low exactly (strobe-setup count + 1) cycles after chip select goes low.
- R3: The write strobe stays low for exactly (strobe-width count + 1) cycles.
- R4: After the write strobe returns high, chip select stays low for exactly (hold count + 1) cycles and then returns high.
- R5: After reset, with no timing register written, a write uses address-setup 0, strobe-setup 0, strobe-width 1 and hold 0.
- R6: Chip select and write strobe are active low and are high during reset and whenever no write is under way; the read strobe is always high.
- R7: The bus data output changes to the request data on the first cycle of the write strobe pulse and holds it through the hold phase; before that, it keeps its previous value.
- R8: The four timing counts are sampled when a request is accepted; a timing register write made during a transfer does not change that transfer, and the following write uses the new values. A timing register write and an acceptance at the same edge give the acceptance the old values.
- R9: The ready output is high exactly when the block is idle, and busy is its complement: high from the cycle after acceptance until the cycle in which chip select returns high.
- R10: A request presented in the cycle in which chip select returns high is accepted at that cycle's edge, and chip select then stays high for the new write's address-setup phase, at least one cycle.
- R11: While idle, the bus address and bus data outputs do not change, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the four timing registers from the cfg inputs |
| cfg_cs_setup | input | CNT_W | Address-setup count (cycles before chip select, minus one) |
| cfg_wr_setup | input | CNT_W | Strobe-setup count (chip select to write strobe, minus one) |
| cfg_wr_active | input | CNT_W | Strobe-width count (write strobe low time, minus one) |
| cfg_wr_hold | input | CNT_W | Hold count (strobe release to chip select release, minus one) |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Address of the requested write |
| req_data | input | DATA_W | Data of the requested write |
| busy | output | 1 | A write is in progress |
| bus_addr | output | ADDR_W | Bus address output |
| bus_data | output | DATA_W | Bus data output |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, held high |

## Verification
The embedded assertions watch, on every cycle, the ordering relations of the strobes: the write strobe only falls after chip select has been low for a cycle, chip select only rises after the strobe has been high for a cycle, the address is steady when chip select falls, the data is steady while the strobe is low, the read strobe never moves, and address and data stay put while idle. The exact phase lengths for every programmed count, the reset defaults, the snapshot of counts at acceptance and back-to-back acceptance at chip-select release depend on programmed values and history, so only the bench's sweep of all count combinations from 0 to 3, plus the maximum counts, can show them.

// File: rtl/i80_write_timer.sv
module i80_write_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_wr_setup,
  input  logic [CNT_W-1:0]  cfg_wr_active,
  input  logic [CNT_W-1:0]  cfg_wr_hold,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic              bus_rd_n
);

  localparam logic [CNT_W-1:0] ACTIVE_RST = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CSW, S_WR, S_HOLD} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  prog_cs, prog_ws, prog_wa, prog_wh;
  logic [CNT_W-1:0]  snap_ws, snap_wa, snap_wh;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              cnt_done;

  assign req_ready = (phase == S_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign cnt_done  = (cnt == '0);
  assign bus_cs_n  = !(phase == S_CSW || phase == S_WR || phase == S_HOLD);
  assign bus_wr_n  = (phase != S_WR);
  assign bus_rd_n  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cs <= '0;
      prog_ws <= '0;
      prog_wa <= ACTIVE_RST;
      prog_wh <= '0;
    end else if (cfg_we) begin
      prog_cs <= cfg_cs_setup;
      prog_ws <= cfg_wr_setup;
      prog_wa <= cfg_wr_active;
      prog_wh <= cfg_wr_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      cnt      <= '0;
      snap_ws  <= '0;
      snap_wa  <= '0;
      snap_wh  <= '0;
      data_q   <= '0;
      bus_addr <= '0;
      bus_data <= '0;
    end else if (accept) begin
      phase    <= S_ADDR;
      cnt      <= prog_cs;
      snap_ws  <= prog_ws;
      snap_wa  <= prog_wa;
      snap_wh  <= prog_wh;
      data_q   <= req_data;
      bus_addr <= req_addr;
    end else begin
      case (phase)
        S_ADDR: begin
          if (cnt_done) begin
            phase <= S_CSW;
            cnt   <= snap_ws;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CSW: begin
          if (cnt_done) begin
            phase    <= S_WR;
            cnt      <= snap_wa;
            bus_data <= data_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WR: begin
          if (cnt_done) begin
            phase <= S_HOLD;
            cnt   <= snap_wh;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt_done) phase <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  assert_accept_starts_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && bus_cs_n && bus_wr_n)
    else $error("accepted write did not start with chip select high");

  assert_addr_stable_at_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $stable(bus_addr))
    else $error("address moved as chip select fell");

  assert_strobe_after_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> !bus_cs_n && $past(!bus_cs_n))
    else $error("write strobe fell without a chip select setup cycle");

  assert_strobe_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_cs_n)
    else $error("write strobe low outside chip select");

  assert_hold_before_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> $past(bus_wr_n) && !busy)
    else $error("chip select released without a hold cycle");

  assert_data_steady_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && !$fell(bus_wr_n)) |-> $stable(bus_data))
    else $error("data changed during write strobe");

  assert_read_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n)
    else $error("read strobe asserted");

  assert_idle_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(bus_addr) && $stable(bus_data))
    else $error("bus outputs changed while idle");

endmodule

// File: tb/i80_write_timer_bench.sv
module i80_write_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_cs_setup = '0, cfg_wr_setup = '0, cfg_wr_active = '0, cfg_wr_hold = '0;
  logic        req_valid = 1'b0;
  logic        req_ready, busy;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic [7:0]  bus_addr;
  logic [15:0] bus_data;
  logic        bus_cs_n, bus_wr_n, bus_rd_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] last_data = '0;

  always #2.5 clk = ~clk;

  i80_write_timer u_i80_write_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_cs_setup(cfg_cs_setup), .cfg_wr_setup(cfg_wr_setup),
    .cfg_wr_active(cfg_wr_active), .cfg_wr_hold(cfg_wr_hold),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  task automatic program_cfg(input logic [3:0] cs, input logic [3:0] ws,
                             input logic [3:0] wa, input logic [3:0] wh);
    cfg_we = 1'b1;
    cfg_cs_setup = cs; cfg_wr_setup = ws; cfg_wr_active = wa; cfg_wr_hold = wh;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_write(input logic [7:0] a, input logic [15:0] d,
                           input int cs, input int ws, input int wa, input int wh,
                           input bit midcfg);
    int pa, pb, pc, tot;
    pa = cs + 1; pb = pa + ws + 1; pc = pb + wa + 1; tot = pc + wh + 1;
    check("R9 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(posedge clk);
    for (int i = 0; i < tot; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 1'b0;
        req_addr = ~a; req_data = ~d;
        if (midcfg) begin
          cfg_we = 1'b1;
          cfg_cs_setup = 4'd2; cfg_wr_setup = 4'd0; cfg_wr_active = 4'd3; cfg_wr_hold = 4'd1;
        end
      end
      if (i == 1) cfg_we = 1'b0;
      if (i < pa) check("R1 cs_n in address setup", 32'(bus_cs_n), 32'd1);
      else if (i < pb) check("R2 cs_n before strobe", 32'(bus_cs_n), 32'd0);
      else if (i < pc) check("R3 cs_n during strobe", 32'(bus_cs_n), 32'd0);
      else check("R4 cs_n in hold", 32'(bus_cs_n), 32'd0);
      if (i >= pb && i < pc) check("R3 wr_n in strobe", 32'(bus_wr_n), 32'd0);
      else check("R2 wr_n outside strobe", 32'(bus_wr_n), 32'd1);
      check("R1 bus address", 32'(bus_addr), 32'(a));
      check("R7 bus data", 32'(bus_data), (i >= pb) ? 32'(d) : 32'(last_data));
      check("R9 busy during write", 32'(busy), 32'd1);
      check("R9 ready during write", 32'(req_ready), 32'd0);
      check("R6 rd_n high", 32'(bus_rd_n), 32'd1);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    check("R4 cs_n released", 32'(bus_cs_n), 32'd1);
    check("R6 wr_n idle", 32'(bus_wr_n), 32'd1);
    check("R9 busy cleared", 32'(busy), 32'd0);
    check("R10 ready at release", 32'(req_ready), 32'd1);
    check("R7 data held after hold", 32'(bus_data), 32'(d));
    last_data = d;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R6 reset cs_n", 32'(bus_cs_n), 32'd1);
    check("R6 reset wr_n", 32'(bus_wr_n), 32'd1);
    check("R6 reset rd_n", 32'(bus_rd_n), 32'd1);
    check("R9 reset ready", 32'(req_ready), 32'd1);
    check("R9 reset busy", 32'(busy), 32'd0);
    check("R11 reset addr", 32'(bus_addr), 32'd0);
    check("R11 reset data", 32'(bus_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: defaults 0,0,1,0 without any timing register write
    run_write(8'h5A, 16'hA5C3, 0, 0, 1, 0, 1'b0);

    // R1..R4 sweep over all counts 0..3
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 4; h++) begin
            program_cfg(4'(c), 4'(s), 4'(w), 4'(h));
            run_write(8'(c * 64 + s * 16 + w * 4 + h), 16'(16'h1357 * (c + s + w + h + 1)),
                      c, s, w, h, 1'b0);
          end

    // R10: back-to-back writes accepted in the release cycle
    program_cfg(4'd1, 4'd0, 4'd0, 4'd2);
    run_write(8'h11, 16'h0F0F, 1, 0, 0, 2, 1'b0);
    run_write(8'h22, 16'hF0F0, 1, 0, 0, 2, 1'b0);
    program_cfg(4'd0, 4'd0, 4'd0, 4'd0);
    run_write(8'h33, 16'h1234, 0, 0, 0, 0, 1'b0);
    run_write(8'h44, 16'h4321, 0, 0, 0, 0, 1'b0);

    // R8: reprogramming mid-transfer applies only to the next write
    program_cfg(4'd0, 4'd1, 4'd0, 4'd0);
    run_write(8'h66, 16'hBEEF, 0, 1, 0, 0, 1'b1);
    run_write(8'h77, 16'hCAFE, 2, 0, 3, 1, 1'b0);

    // R1..R4 at maximum counts
    program_cfg(4'd15, 4'd15, 4'd15, 4'd15);
    run_write(8'hFF, 16'hFFFF, 15, 15, 15, 15, 1'b0);

    // R11: idle outputs ignore request inputs while valid is low
    for (int k = 0; k < 6; k++) begin
      req_addr = 8'(k * 37); req_data = 16'(k * 4099);
      @(negedge clk);
      check("R11 idle addr held", 32'(bus_addr), 32'hFF);
      check("R11 idle data held", 32'(bus_data), 32'hFFFF);
      check("R6 idle cs_n", 32'(bus_cs_n), 32'd1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule